// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block keeps the eight-bit status byte of a small serial NOR flash and owns its write-protect state. An upstream instruction decoder hands it one-cycle command strobes: set the write-enable latch, clear it, write the status byte (with a data byte), read the status byte, and request a program or erase. The array sequencer hands it completion pulses for program and erase and a live busy flag. The active-low write-protect pin enters directly.

The block returns the status byte, both as a continuous view and as a registered read result. It also flags whether a program/erase request may start, and decodes whether a given byte address lies inside the protected region. The protection fields are held in plain registers that stand in for non-volatile cells. Power-on reset loads them so that the whole array is protected.

Top module: `sfsr_ctrl`

## Requirements
- R1: Status layout: bit0 = busy_in, bit1 = write-enable latch, bits 4:2 = protect level, bit5 = bottom-anchor flag, bit6 always 0, bit7 = lock bit. A read strobe returns that byte on rd_data one cycle later with rd_valid high, and this is accepted while busy.
- R2: After por_n is released, the latch is 0, the protect level is 111, the anchor flag is 0 and the lock bit is 0, so the status reads 0x1C.
- R3: A write-enable strobe while busy_in is 0 sets the latch on the next cycle. While busy_in is 1 it is ignored.
- R4: The latch clears on the next cycle after a program-done pulse, an erase-done pulse, a write-disable strobe taken while not busy, or an accepted status write. A clear beats a write-enable strobe in the same cycle.
- R5: A status write is accepted only when busy_in is 0 and the latch is 1. Otherwise bits 7:2 keep their values.
- R6: An accepted status write loads data[7] into the lock bit. It loads data[4:2] and data[5] into the level and anchor flag only when the lock bit was 0 and wp_n is high. Data bits 6, 1 and 0 are ignored.
- R7: pe_grant is high in the same cycle as cmd_pe exactly when the latch is 1 and busy_in is 0.
- R8: Level 000 protects nothing and 111 protects every address. A level k from 1 to 6 protects 2^(ADDR_W-7+k) bytes, at the highest addresses when the anchor flag is 0 and at the lowest when it is 1.
- R9: A write-disable strobe while busy_in is 1 leaves the latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low |
| cmd_wren | input | 1 | Write-enable command strobe |
| cmd_wrdi | input | 1 | Write-disable command strobe |
| cmd_wrsr | input | 1 | Status write command strobe |
| wrsr_data | input | 8 | Data byte for a status write |
| cmd_rdsr | input | 1 | Status read command strobe |
| cmd_pe | input | 1 | Program/erase request |
| done_prog | input | 1 | Program completion pulse |
| done_erase | input | 1 | Erase completion pulse (any size) |
| busy_in | input | 1 | Internal operation running |
| wp_n | input | 1 | Write-protect pin, active low |
| chk_addr | input | ADDR_W | Byte address to test against the protected region |
| status_q | output | 8 | Live status byte |
| rd_data | output | 8 | Registered status read result |
| rd_valid | output | 1 | rd_data valid |
| wel_o | output | 1 | Write-enable latch |
| pe_grant | output | 1 | Program/erase request may start |
| addr_prot | output | 1 | chk_addr lies in the protected region |

## Verification
A write-enable strobe can arrive in the same cycle as an event that clears the latch: a program or erase completion, or a status write that the latch itself admits. The bench drives these pairs in one cycle, both with the latch already set and with it clear. It then reads the status byte back through the normal read path. The latch must read 0, and an accepted status write must still have applied its fields.

// File: rtl/sfsr_pkg.sv
package sfsr_pkg;
   localparam int SR_W      = 8;
   localparam int LVL_W     = 3;
   localparam int B_BUSY    = 0;
   localparam int B_WEL     = 1;
   localparam int B_LVL_LO  = 2;
   localparam int B_ANCHOR  = 5;
   localparam int B_LOCK    = 7;

   typedef struct packed {
      logic             lock;
      logic             anchor;
      logic [LVL_W-1:0] lvl;
   } prot_t;
endpackage

// File: rtl/sfsr_wel.sv
module sfsr_wel (
   input  logic clk,
   input  logic por_n,
   input  logic busy,
   input  logic set_req,
   input  logic clr_req,
   output logic wel
);
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         wel <= 1'b0;
      else if (clr_req)
         wel <= 1'b0;
      else if (set_req && !busy)
         wel <= 1'b1;
   end
endmodule

// File: rtl/sfsr_prot_regs.sv
module sfsr_prot_regs
   import sfsr_pkg::*;
#(
   parameter logic [LVL_W-1:0] POR_LVL = '1,
   parameter bit               HAS_ANCHOR = 1'b1
) (
   input  logic            clk,
   input  logic            por_n,
   input  logic            wr_ok,
   input  logic            wp_n,
   input  logic [SR_W-1:0] wr_data,
   output prot_t           prot
);
   logic fields_open;
   logic anchor_in;

   assign fields_open = wr_ok && !prot.lock && wp_n;

   generate
      if (HAS_ANCHOR) begin : g_anchor
         assign anchor_in = wr_data[B_ANCHOR];
      end else begin : g_no_anchor
         assign anchor_in = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         prot.lock   <= 1'b0;
         prot.anchor <= 1'b0;
         prot.lvl    <= POR_LVL;
      end else begin
         if (fields_open) begin
            prot.lvl    <= wr_data[B_LVL_LO +: LVL_W];
            prot.anchor <= anchor_in;
         end
         if (wr_ok)
            prot.lock <= wr_data[B_LOCK];
      end
   end
endmodule

// File: rtl/sfsr_range_dec.sv
module sfsr_range_dec
   import sfsr_pkg::*;
#(
   parameter int ADDR_W     = 19,
   parameter bit HAS_ANCHOR = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [LVL_W-1:0]  lvl,
   input  logic              anchor,
   output logic              hit
);
   localparam int LVL_MAX = (1 << LVL_W) - 1;

   logic [LVL_MAX:0] lvl_hit;

   generate
      if (ADDR_W < LVL_MAX) begin : g_bad_width
         $error("sfsr_range_dec: ADDR_W too small for the level count");
      end

      assign lvl_hit[0]       = 1'b0;
      assign lvl_hit[LVL_MAX] = 1'b1;

      for (genvar k = 1; k < LVL_MAX; k++) begin : g_lvl
         localparam int NB = LVL_MAX - k;
         logic top_m;
         logic bot_m;
         assign top_m = &addr[ADDR_W-1 -: NB];
         assign bot_m = ~|addr[ADDR_W-1 -: NB];
         if (HAS_ANCHOR) begin : g_sel
            assign lvl_hit[k] = anchor ? bot_m : top_m;
         end else begin : g_top
            assign lvl_hit[k] = top_m;
         end
      end
   endgenerate

   assign hit = lvl_hit[lvl];
endmodule

// File: rtl/sfsr_ctrl.sv
module sfsr_ctrl
   import sfsr_pkg::*;
#(
   parameter int               ADDR_W     = 19,
   parameter logic [LVL_W-1:0] POR_LVL    = '1,
   parameter bit               HAS_ANCHOR = 1'b1
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              cmd_wren,
   input  logic              cmd_wrdi,
   input  logic              cmd_wrsr,
   input  logic [SR_W-1:0]   wrsr_data,
   input  logic              cmd_rdsr,
   input  logic              cmd_pe,
   input  logic              done_prog,
   input  logic              done_erase,
   input  logic              busy_in,
   input  logic              wp_n,
   input  logic [ADDR_W-1:0] chk_addr,
   output logic [SR_W-1:0]   status_q,
   output logic [SR_W-1:0]   rd_data,
   output logic              rd_valid,
   output logic              wel_o,
   output logic              pe_grant,
   output logic              addr_prot
);
   prot_t prot;
   logic  wel;
   logic  wrsr_ok;
   logic  wel_clr;

   assign wrsr_ok = cmd_wrsr && !busy_in && wel;
   assign wel_clr = done_prog || done_erase || (cmd_wrdi && !busy_in) || wrsr_ok;

   sfsr_wel u_wel (
      .clk     (clk),
      .por_n   (por_n),
      .busy    (busy_in),
      .set_req (cmd_wren),
      .clr_req (wel_clr),
      .wel     (wel)
   );

   sfsr_prot_regs #(
      .POR_LVL    (POR_LVL),
      .HAS_ANCHOR (HAS_ANCHOR)
   ) u_prot (
      .clk     (clk),
      .por_n   (por_n),
      .wr_ok   (wrsr_ok),
      .wp_n    (wp_n),
      .wr_data (wrsr_data),
      .prot    (prot)
   );

   sfsr_range_dec #(
      .ADDR_W     (ADDR_W),
      .HAS_ANCHOR (HAS_ANCHOR)
   ) u_dec (
      .addr   (chk_addr),
      .lvl    (prot.lvl),
      .anchor (prot.anchor),
      .hit    (addr_prot)
   );

   always_comb begin
      status_q                      = '0;
      status_q[B_BUSY]              = busy_in;
      status_q[B_WEL]               = wel;
      status_q[B_LVL_LO +: LVL_W]   = prot.lvl;
      status_q[B_ANCHOR]            = prot.anchor;
      status_q[B_LOCK]              = prot.lock;
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= cmd_rdsr;
         if (cmd_rdsr)
            rd_data <= status_q;
      end
   end

   assign wel_o    = wel;
   assign pe_grant = cmd_pe && wel && !busy_in;
endmodule

// File: rtl/sfsr_chk.sv
module sfsr_chk (
   input logic       clk,
   input logic       por_n,
   input logic       cmd_wren,
   input logic       cmd_wrdi,
   input logic       cmd_wrsr,
   input logic       cmd_rdsr,
   input logic       done_prog,
   input logic       done_erase,
   input logic       busy_in,
   input logic       wp_n,
   input logic [7:0] status_q,
   input logic [7:0] rd_data,
   input logic       rd_valid,
   input logic       wel_o,
   input logic       pe_grant,
   input logic       addr_prot
);
   p_read_r1: assert property (@(posedge clk) disable iff (!por_n)
      cmd_rdsr |=> (rd_valid && rd_data == $past(status_q)));

   p_wren_sets_r3: assert property (@(posedge clk) disable iff (!por_n)
      (cmd_wren && !busy_in && !done_prog && !done_erase && !cmd_wrdi && !cmd_wrsr) |=> wel_o);

   p_busy_hold_r3: assert property (@(posedge clk) disable iff (!por_n)
      (busy_in && !wel_o) |=> !wel_o);

   p_done_clears_r4: assert property (@(posedge clk) disable iff (!por_n)
      (done_prog || done_erase) |=> !wel_o);

   p_wrsr_gate_r5: assert property (@(posedge clk) disable iff (!por_n)
      (cmd_wrsr && (busy_in || !wel_o)) |=> $stable(status_q[7:2]));

   p_lock_r6: assert property (@(posedge clk) disable iff (!por_n)
      (cmd_wrsr && status_q[7]) |=> $stable(status_q[5:2]));

   p_wp_pin_r6: assert property (@(posedge clk) disable iff (!por_n)
      (cmd_wrsr && !wp_n) |=> $stable(status_q[5:2]));

   p_grant_r7: assert property (@(posedge clk) disable iff (!por_n)
      pe_grant |-> (wel_o && !busy_in));

   p_full_r8: assert property (@(posedge clk) disable iff (!por_n)
      (status_q[4:2] == 3'b111) |-> addr_prot);

   p_none_r8: assert property (@(posedge clk) disable iff (!por_n)
      (status_q[4:2] == 3'b000) |-> !addr_prot);

   p_wrdi_busy_r9: assert property (@(posedge clk) disable iff (!por_n)
      (cmd_wrdi && busy_in && wel_o && !done_prog && !done_erase) |=> wel_o);
endmodule

bind sfsr_ctrl sfsr_chk u_chk (
   .clk        (clk),
   .por_n      (por_n),
   .cmd_wren   (cmd_wren),
   .cmd_wrdi   (cmd_wrdi),
   .cmd_wrsr   (cmd_wrsr),
   .cmd_rdsr   (cmd_rdsr),
   .done_prog  (done_prog),
   .done_erase (done_erase),
   .busy_in    (busy_in),
   .wp_n       (wp_n),
   .status_q   (status_q),
   .rd_data    (rd_data),
   .rd_valid   (rd_valid),
   .wel_o      (wel_o),
   .pe_grant   (pe_grant),
   .addr_prot  (addr_prot)
);

// File: tb/tb_sfsr_ctrl.sv
module tb_sfsr_ctrl;
   localparam int CLK_P  = 10;
   localparam int ADDR_W = 19;

   logic              clk = 1'b0;
   logic              por_n = 1'b0;
   logic              cmd_wren = 1'b0, cmd_wrdi = 1'b0, cmd_wrsr = 1'b0, cmd_rdsr = 1'b0;
   logic              cmd_pe = 1'b0, done_prog = 1'b0, done_erase = 1'b0;
   logic              busy_in = 1'b0, wp_n = 1'b1;
   logic [7:0]        wrsr_data = '0;
   logic [ADDR_W-1:0] chk_addr = '0;
   logic [7:0]        status_q, rd_data;
   logic              rd_valid, wel_o, pe_grant, addr_prot;

   int checks = 0;
   int errors = 0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   logic       m_wel = 1'b0, m_tb = 1'b0, m_bpl = 1'b0;
   logic [2:0] m_bp = 3'b111;

   always #(CLK_P/2) clk = ~clk;

   sfsr_ctrl #(.ADDR_W(ADDR_W)) dut (
      .clk(clk), .por_n(por_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
      .cmd_wrsr(cmd_wrsr), .wrsr_data(wrsr_data), .cmd_rdsr(cmd_rdsr),
      .cmd_pe(cmd_pe), .done_prog(done_prog), .done_erase(done_erase),
      .busy_in(busy_in), .wp_n(wp_n), .chk_addr(chk_addr),
      .status_q(status_q), .rd_data(rd_data), .rd_valid(rd_valid),
      .wel_o(wel_o), .pe_grant(pe_grant), .addr_prot(addr_prot)
   );

   function automatic logic [7:0] m_status();
      return {m_bpl, 1'b0, m_tb, m_bp, m_wel, busy_in};
   endfunction

   function automatic logic m_prot(logic [ADDR_W-1:0] a);
      longint sz;
      if (m_bp == 3'd0) return 1'b0;
      if (m_bp == 3'd7) return 1'b1;
      sz = longint'(1) << (ADDR_W - 7 + int'(m_bp));
      if (m_tb) return longint'(a) < sz;
      return longint'(a) >= ((longint'(1) << ADDR_W) - sz);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // one-cycle command pulse; model updated from the requirements
   task automatic step(logic wren, logic wrdi, logic wrsr, logic [7:0] d, logic dp, logic de);
      logic wr_ok, clr;
      @(negedge clk);
      cmd_wren = wren; cmd_wrdi = wrdi; cmd_wrsr = wrsr; wrsr_data = d;
      done_prog = dp; done_erase = de;
      wr_ok = wrsr && !busy_in && m_wel;
      clr   = dp || de || (wrdi && !busy_in) || wr_ok;
      if (wr_ok) begin
         if (!m_bpl && wp_n) begin
            m_bp = d[4:2];
            m_tb = d[5];
         end
         m_bpl = d[7];
      end
      if (clr) m_wel = 1'b0;
      else if (wren && !busy_in) m_wel = 1'b1;
      @(negedge clk);
      cmd_wren = 0; cmd_wrdi = 0; cmd_wrsr = 0; done_prog = 0; done_erase = 0;
   endtask

   task automatic read_sr(string tag);
      @(negedge clk);
      cmd_rdsr = 1'b1;
      exp_q.push_back(m_status());
      tag_q.push_back(tag);
      @(negedge clk);
      cmd_rdsr = 1'b0;
   endtask

   task automatic prot_chk(logic [ADDR_W-1:0] a);
      @(negedge clk);
      chk_addr = a;
      #1;
      check("R8 range", 32'(addr_prot), 32'(m_prot(a)));
   endtask

   task automatic grant_chk(string tag);
      @(negedge clk);
      cmd_pe = 1'b1;
      #1;
      check(tag, 32'(pe_grant), 32'(m_wel && !busy_in));
      cmd_pe = 1'b0;
   endtask

   // monitor: pops the scoreboard whenever a read result appears
   always @(negedge clk) begin
      if (rd_valid) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R1: unexpected read actual %0h expected none", rd_data);
         end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, 32'(rd_data), 32'(e));
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);
      check("R2 reset status", 32'(status_q), 32'h1C);
      check("R2 reset rd_valid", 32'(rd_valid), 32'h0);
      read_sr("R2 R1 read after reset");
      prot_chk('0);                              // R8 all protected
      // R5: write refused with latch clear
      step(0, 0, 1, 8'h00, 0, 0);
      read_sr("R5 write without latch");
      grant_chk("R7 no latch");
      // R3: set latch
      step(1, 0, 0, 8'h00, 0, 0);
      read_sr("R3 latch set");
      grant_chk("R7 latch set");
      // R6 R4: clear protection, latch drops
      step(0, 0, 1, 8'h00, 0, 0);
      read_sr("R6 R4 write level 0");
      prot_chk('1);
      prot_chk('0);
      // R6 R1: level 3 top, ignored bits set
      step(1, 0, 0, 8'h00, 0, 0);
      step(0, 0, 1, 8'h4F, 0, 0);
      read_sr("R6 R1 ignored bits");
      prot_chk(19'h77FFF);
      prot_chk(19'h78000);
      prot_chk(19'h00000);
      // R8: bottom anchor
      step(1, 0, 0, 8'h00, 0, 0);
      step(0, 0, 1, 8'h2C, 0, 0);
      read_sr("R6 anchor bottom");
      prot_chk(19'h07FFF);
      prot_chk(19'h08000);
      prot_chk(19'h7FFFF);
      // level 6 top half
      step(1, 0, 0, 8'h00, 0, 0);
      step(0, 0, 1, 8'h18, 0, 0);
      read_sr("R6 level 6");
      prot_chk(19'h3FFFF);
      prot_chk(19'h40000);
      // R6: wp pin low blocks fields
      wp_n = 1'b0;
      step(1, 0, 0, 8'h00, 0, 0);
      step(0, 0, 1, 8'h00, 0, 0);
      read_sr("R6 wp pin low");
      wp_n = 1'b1;
      // R6: lock
      step(1, 0, 0, 8'h00, 0, 0);
      step(0, 0, 1, 8'hBC, 0, 0);
      read_sr("R6 set lock");
      step(1, 0, 0, 8'h00, 0, 0);
      step(0, 0, 1, 8'h80, 0, 0);
      read_sr("R6 locked fields");
      step(1, 0, 0, 8'h00, 0, 0);
      step(0, 0, 1, 8'h00, 0, 0);
      read_sr("R6 unlock keeps fields");
      step(1, 0, 0, 8'h00, 0, 0);
      step(0, 0, 1, 8'h00, 0, 0);
      read_sr("R6 clear after unlock");
      // R3 R1: busy
      @(negedge clk); busy_in = 1'b1;
      step(1, 0, 0, 8'h00, 0, 0);
      read_sr("R3 R1 wren while busy");
      @(negedge clk); busy_in = 1'b0;
      step(1, 0, 0, 8'h00, 0, 0);
      @(negedge clk); busy_in = 1'b1;
      grant_chk("R7 busy");
      step(0, 1, 0, 8'h00, 0, 0);
      read_sr("R9 wrdi while busy");
      step(0, 0, 1, 8'h9C, 0, 0);
      read_sr("R5 write while busy");
      // R4: completions
      step(0, 0, 0, 8'h00, 1, 0);
      @(negedge clk); busy_in = 1'b0;
      read_sr("R4 program done");
      step(1, 0, 0, 8'h00, 0, 0);
      step(0, 0, 0, 8'h00, 0, 1);
      read_sr("R4 erase done");
      step(1, 0, 0, 8'h00, 0, 0);
      step(0, 1, 0, 8'h00, 0, 0);
      read_sr("R4 wrdi");
      // R4: same-cycle races
      step(1, 0, 0, 8'h00, 1, 0);
      read_sr("R4 wren vs program done");
      step(1, 0, 0, 8'h00, 0, 0);
      step(1, 0, 0, 8'h00, 0, 1);
      read_sr("R4 wren vs erase done");
      step(1, 0, 0, 8'h00, 0, 0);
      step(1, 0, 1, 8'h08, 0, 0);
      read_sr("R4 R6 wren vs status write");
      repeat (3) @(negedge clk);
      check("R1 scoreboard drained", 32'(exp_q.size()), 32'h0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule